// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable inputs together with the bank and address pins, and turns them into one command. It keeps an open/closed flag and a latched row for each of four banks. A burst engine steps through the column addresses of a read or write and raises one array strobe per beat. During read beats it also drives the data-output enable.

Internal strobes cover activate, precharge (explicit or automatic), mode-register load, array read and array write. Address bit 10 picks the variant of a command: auto-precharge for reads and writes, and all banks for precharge. The mode register holds the burst length and a single-write option. When single-write is set, every write is one beat long, whatever burst length is programmed. A command that breaks the bank rules raises a one-cycle illegal flag and has no other effect.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: With cs_ni low, the strobe code {ras_ni,cas_ni,we_ni} decodes as 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 000 mode load, and 001 as no-op. Every strobe output shows the result in the cycle after the sampling edge.
- R2: With cs_ni high, the other command pins are ignored. A running burst keeps stepping, and the bank flags and mode stay as they were.
- R3: A legal activate opens bank ba_i and latches addr_i as its row; act_stb_o pulses with that bank and row. Precharge closes bank ba_i when addr_i[10]=0, or all banks when addr_i[10]=1. pre_stb_o pulses with pre_mask_o naming the closed banks.
- R4: A legal read raises rd_stb_o and dq_oe_o for exactly burst-length cycles, from the cycle after the command. The columns start at addr_i[9:0] and wrap inside the aligned block of burst length. rw_bank_o and rw_row_o give the bank and its latched row.
- R5: A legal write raises wr_stb_o with the same beat count and column sequence as a read, and dq_oe_o stays low.
- R6: A burst stop ends the running burst: no beat follows it, and the bank stays open.
- R7: A read or write with addr_i[10]=1 closes its bank on the edge that ends the last beat. pre_stb_o pulses in the next cycle with that bank in pre_mask_o. A burst stop, or a new read or write before the last beat, cancels the automatic precharge.
- R8: Mode load sets burst length from addr_i[2:0] (000=1, 001=2, 010=4, 011=8, 1xx=1) and single-write from addr_i[9]. With single-write set, writes last one beat while reads keep the programmed length. After reset the burst length is 1 and single-write is off.
- R9: Activate to an open bank, and read or write to a closed bank, pulse illegal_o and change no state.
- R10: Mode load is accepted only when all banks are closed. Otherwise illegal_o pulses and the mode is unchanged.
- R11: A bank whose automatic precharge completes on an edge counts as closed for the command sampled on that edge. An activate to it is legal and leaves it open; a read or write to it is illegal.
- R12: Reset clears all bank flags, stops any burst and drives every strobe, dq_oe_o and illegal_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, commands sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Row, column and option bits |
| act_stb_o | output | 1 | Activate strobe |
| act_bank_o | output | 2 | Bank being activated |
| act_row_o | output | 13 | Row being activated |
| pre_stb_o | output | 1 | Precharge strobe, explicit or automatic |
| pre_mask_o | output | 4 | Banks precharged |
| mrs_stb_o | output | 1 | Mode-register load strobe |
| rd_stb_o | output | 1 | Array read beat |
| wr_stb_o | output | 1 | Array write beat |
| dq_oe_o | output | 1 | Data-output enable |
| rw_bank_o | output | 2 | Bank of current beat |
| rw_row_o | output | 13 | Row of current beat |
| rw_col_o | output | 10 | Column of current beat |
| illegal_o | output | 1 | Rule violation pulse |
| bank_open_o | output | 4 | Open flag per bank |

## Verification
Two events can land on the same edge: the end of an auto-precharging burst, and a new command aimed at the same bank. The bench sets a two-beat length and issues the auto-precharge read followed by one no-op. On the next edge, the edge that retires the last beat, it then issues either an activate or a read to that bank. In the activate case it expects act_stb_o and pre_stb_o to pulse together and the bank to end up open. In the read case it expects illegal_o, the precharge pulse and no new beats.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
  localparam int BL_LOG_W = 2;  // burst length 1,2,4,8
  localparam int CNT_W    = 3;

  typedef enum logic [2:0] {
    CMD_DESL,
    CMD_NOP,
    CMD_BST,
    CMD_RD,
    CMD_WR,
    CMD_ACT,
    CMD_PRE,
    CMD_MRS
  } cmd_e;
endpackage

// File: rtl/sdr_cmd_dec.sv
module sdr_cmd_dec
  import sdr_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_DESL;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b110:  cmd_o = CMD_BST;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;  // 111, and 001 (refresh) folded in
      endcase
    end
  end
endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_cmd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2:0]          bl_code_i,
  input  logic                single_i,
  output logic [BL_LOG_W-1:0] bl_log_o,
  output logic                single_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_log_o    <= '0;
      single_wr_o <= 1'b0;
    end else if (load_i) begin
      bl_log_o    <= bl_code_i[2] ? '0 : bl_code_i[1:0];
      single_wr_o <= single_i;
    end
  end
endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            act_i,
  input  logic [BA_W-1:0]                 act_bank_i,
  input  logic [ROW_W-1:0]                act_row_i,
  input  logic [NUM_BANKS-1:0]            close_mask_i,
  output logic [NUM_BANKS-1:0]            open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = act_i && (act_bank_i == BA_W'(b));

    // activate wins over a close landing on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        rows_o[b] <= '0;
      end else if (hit) begin
        open_o[b] <= 1'b1;
        rows_o[b] <= act_row_i;
      end else if (close_mask_i[b]) begin
        open_o[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl
  import sdr_cmd_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int BA_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                start_wr_i,
  input  logic                start_ap_i,
  input  logic [BA_W-1:0]     start_bank_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [BL_LOG_W-1:0] start_bl_log_i,
  input  logic                stop_i,
  output logic                rd_o,
  output logic                wr_o,
  output logic [BA_W-1:0]     bank_o,
  output logic [COL_W-1:0]    col_o,
  output logic                ap_done_o
);
  logic             busy_q, wr_q, ap_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q, len_m1_q;
  logic             last;
  logic [COL_W-1:0] mask_w, off_w;

  assign last      = busy_q && (cnt_q == len_m1_q);
  assign ap_done_o = last && ap_q && !stop_i;

  // wrap inside the aligned block of burst length
  assign mask_w = COL_W'(len_m1_q);
  assign off_w  = base_q + COL_W'(cnt_q);
  assign col_o  = (base_q & ~mask_w) | (off_w & mask_w);

  assign rd_o   = busy_q && !wr_q;
  assign wr_o   = busy_q && wr_q;
  assign bank_o = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      ap_q     <= 1'b0;
      bank_q   <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      len_m1_q <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      wr_q     <= start_wr_i;
      ap_q     <= start_ap_i;
      bank_q   <= start_bank_i;
      base_q   <= start_col_i;
      cnt_q    <= '0;
      len_m1_q <= (CNT_W'(1) << start_bl_log_i) - CNT_W'(1);
    end else if (stop_i) begin
      busy_q <= 1'b0;
      ap_q   <= 1'b0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        ap_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl
  import sdr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int SW_BIT    = 9,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 act_stb_o,
  output logic [BA_W-1:0]      act_bank_o,
  output logic [ROW_W-1:0]     act_row_o,
  output logic                 pre_stb_o,
  output logic [NUM_BANKS-1:0] pre_mask_o,
  output logic                 mrs_stb_o,
  output logic                 rd_stb_o,
  output logic                 wr_stb_o,
  output logic                 dq_oe_o,
  output logic [BA_W-1:0]      rw_bank_o,
  output logic [ROW_W-1:0]     rw_row_o,
  output logic [COL_W-1:0]     rw_col_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] bank_open_o
);
  localparam logic [NUM_BANKS-1:0] ONE = NUM_BANKS'(1);

  cmd_e                            cmd;
  logic                            a10;
  logic [BL_LOG_W-1:0]             bl_log;
  logic                            single_wr;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
  logic                            ap_done;
  logic [BA_W-1:0]                 burst_bank;
  logic [NUM_BANKS-1:0]            ap_mask, open_eff, close_mask, pre_cmd_mask;
  logic                            tgt_open;
  logic                            is_rw, act_ok, rw_ok, mrs_ok, bad;
  logic [BL_LOG_W-1:0]             start_bl_log;

  sdr_cmd_dec u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  assign a10 = addr_i[AP_BIT];

  // bank closing by auto-precharge on this edge counts as closed now
  assign ap_mask  = ap_done ? (ONE << burst_bank) : '0;
  assign open_eff = bank_open_o & ~ap_mask;
  assign tgt_open = open_eff[ba_i];

  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign act_ok = (cmd == CMD_ACT) && !tgt_open;
  assign rw_ok  = is_rw && tgt_open;
  assign mrs_ok = (cmd == CMD_MRS) && (open_eff == '0);
  assign bad    = ((cmd == CMD_ACT) && tgt_open) ||
                  (is_rw && !tgt_open) ||
                  ((cmd == CMD_MRS) && (open_eff != '0));

  assign pre_cmd_mask = a10 ? '1 : (ONE << ba_i);
  assign close_mask   = ap_mask | ((cmd == CMD_PRE) ? pre_cmd_mask : '0);

  assign start_bl_log = ((cmd == CMD_WR) && single_wr) ? '0 : bl_log;

  sdr_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mrs_ok),
    .bl_code_i  (addr_i[2:0]),
    .single_i   (addr_i[SW_BIT]),
    .bl_log_o   (bl_log),
    .single_wr_o(single_wr)
  );

  sdr_bank_table #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
  ) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_ok),
    .act_bank_i  (ba_i),
    .act_row_i   (addr_i[ROW_W-1:0]),
    .close_mask_i(close_mask),
    .open_o      (bank_open_o),
    .rows_o      (rows)
  );

  sdr_burst_ctl #(
    .COL_W(COL_W),
    .BA_W (BA_W)
  ) u_burst (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (rw_ok),
    .start_wr_i    (cmd == CMD_WR),
    .start_ap_i    (a10),
    .start_bank_i  (ba_i),
    .start_col_i   (addr_i[COL_W-1:0]),
    .start_bl_log_i(start_bl_log),
    .stop_i        (cmd == CMD_BST),
    .rd_o          (rd_stb_o),
    .wr_o          (wr_stb_o),
    .bank_o        (burst_bank),
    .col_o         (rw_col_o),
    .ap_done_o     (ap_done)
  );

  assign dq_oe_o   = rd_stb_o;
  assign rw_bank_o = burst_bank;
  assign rw_row_o  = rows[burst_bank];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_stb_o  <= 1'b0;
      act_bank_o <= '0;
      act_row_o  <= '0;
      pre_stb_o  <= 1'b0;
      pre_mask_o <= '0;
      mrs_stb_o  <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      act_stb_o  <= act_ok;
      act_bank_o <= ba_i;
      act_row_o  <= addr_i[ROW_W-1:0];
      pre_stb_o  <= |close_mask;
      pre_mask_o <= close_mask;
      mrs_stb_o  <= mrs_ok;
      illegal_o  <= bad;
    end
  end
endmodule

// File: rtl/sdr_cmd_ctrl_chk.sv
module sdr_cmd_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 ras_ni,
  input logic                 cas_ni,
  input logic                 we_ni,
  input logic                 act_stb_o,
  input logic [BA_W-1:0]      act_bank_o,
  input logic                 pre_stb_o,
  input logic [NUM_BANKS-1:0] pre_mask_o,
  input logic                 mrs_stb_o,
  input logic                 rd_stb_o,
  input logic                 wr_stb_o,
  input logic                 illegal_o,
  input logic [NUM_BANKS-1:0] bank_open_o
);
  a_r3_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_stb_o |-> bank_open_o[act_bank_o]);

  a_r7_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_stb_o && !act_stb_o) |-> ((bank_open_o & pre_mask_o) == '0));

  a_r10_mrs_all_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_stb_o |-> (bank_open_o == '0));

  a_r9_illegal_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!act_stb_o && !mrs_stb_o));

  a_r2_desl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!act_stb_o && !mrs_stb_o && !illegal_o));

  a_r6_bst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && ras_ni && cas_ni && !we_ni) |=> (!rd_stb_o && !wr_stb_o));

  a_r5_rw_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));
endmodule

bind sdr_cmd_ctrl sdr_cmd_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ROW_W    (ROW_W),
  .COL_W    (COL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .act_stb_o  (act_stb_o),
  .act_bank_o (act_bank_o),
  .pre_stb_o  (pre_stb_o),
  .pre_mask_o (pre_mask_o),
  .mrs_stb_o  (mrs_stb_o),
  .rd_stb_o   (rd_stb_o),
  .wr_stb_o   (wr_stb_o),
  .illegal_o  (illegal_o),
  .bank_open_o(bank_open_o)
);

// File: tb/sdr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module sdr_cmd_ctrl_tb;
  localparam logic [3:0] C_MRS = 4'h0, C_PRE = 4'h2, C_ACT = 4'h3, C_WR = 4'h4,
                         C_RD = 4'h5, C_BST = 4'h6, C_NOP = 4'h7, C_DESL = 4'h8;

  typedef struct packed {
    logic [3:0]  cmd;   // {cs,ras,cas,we}
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        act;
    logic        pre;
    logic [3:0]  pm;
    logic        mrs;
    logic        ill;
    logic        rd;
    logic        wr;
    logic [9:0]  col;
    logic [3:0]  opn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{C_MRS, 2'd0, 13'h0002, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd10}, // R10 BL4
    '{C_ACT, 2'd1, 13'h0123, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0010, 4'd3},  // R3
    '{C_RD,  2'd1, 13'h0006, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h006, 4'b0010, 4'd4},  // R4
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h007, 4'b0010, 4'd4},
    '{C_DESL,2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h004, 4'b0010, 4'd2},  // R2 wrap too
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h005, 4'b0010, 4'd4},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0010, 4'd4},
    '{C_RD,  2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'b0010, 4'd9},  // R9
    '{C_ACT, 2'd1, 13'h0055, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'b0010, 4'd9},
    '{C_WR,  2'd1, 13'h040A, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h00A, 4'b0010, 4'd5},  // R5
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h00B, 4'b0010, 4'd5},
    '{C_BST, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0010, 4'd6},  // R6
    '{C_WR,  2'd1, 13'h0401, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h001, 4'b0010, 4'd5},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h002, 4'b0010, 4'd5},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h003, 4'b0010, 4'd5},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 4'b0010, 4'd5},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd7},  // R7
    '{C_MRS, 2'd0, 13'h0203, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd8},  // R8 BL8+single
    '{C_ACT, 2'd2, 13'h0005, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0100, 4'd3},
    '{C_RD,  2'd2, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h000, 4'b0100, 4'd4},
    '{C_BST, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0100, 4'd6},
    '{C_WR,  2'd2, 13'h0403, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h003, 4'b0100, 4'd8},
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd8},  // single beat, then AP
    '{C_ACT, 2'd0, 13'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0001, 4'd3},
    '{C_ACT, 2'd3, 13'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b1001, 4'd3},
    '{C_MRS, 2'd0, 13'h0001, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'b1001, 4'd10},
    '{C_PRE, 2'd0, 13'h0400, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd3},  // all
    '{C_ACT, 2'd2, 13'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0100, 4'd3},
    '{C_ACT, 2'd0, 13'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0101, 4'd3},
    '{C_PRE, 2'd2, 13'h0000, 1'b0, 1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0001, 4'd3},  // one
    '{C_RD,  2'd0, 13'h03FF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h3FF, 4'b0001, 4'd4},  // BL8 read
    '{C_NOP, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h3F8, 4'b0001, 4'd4},
    '{C_BST, 2'd0, 13'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0001, 4'd6},
    '{C_PRE, 2'd0, 13'h0000, 1'b0, 1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 4'b0000, 4'd1}   // R1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b0, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic        act_stb_o, pre_stb_o, mrs_stb_o, rd_stb_o, wr_stb_o, dq_oe_o, illegal_o;
  logic [1:0]  act_bank_o, rw_bank_o;
  logic [12:0] act_row_o, rw_row_o;
  logic [3:0]  pre_mask_o, bank_open_o;
  logic [9:0]  rw_col_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  sdr_cmd_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .ba_i(ba_i), .addr_i(addr_i),
    .act_stb_o(act_stb_o), .act_bank_o(act_bank_o), .act_row_o(act_row_o),
    .pre_stb_o(pre_stb_o), .pre_mask_o(pre_mask_o), .mrs_stb_o(mrs_stb_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .dq_oe_o(dq_oe_o),
    .rw_bank_o(rw_bank_o), .rw_row_o(rw_row_o), .rw_col_o(rw_col_o),
    .illegal_o(illegal_o), .bank_open_o(bank_open_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  // drive at negedge, let one edge sample it, return at the next negedge
  task automatic step(input logic [3:0] cmd, input logic [1:0] ba, input logic [12:0] addr);
    {cs_ni, ras_ni, cas_ni, we_ni} = cmd;
    ba_i   = ba;
    addr_i = addr;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12", "strobes", {act_stb_o, pre_stb_o, mrs_stb_o, rd_stb_o, wr_stb_o, dq_oe_o, illegal_o}, 0);
    chk("R12", "open", bank_open_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", VEC[i].req, i);
      step(VEC[i].cmd, VEC[i].ba, VEC[i].addr);
      chk(tag, "act", act_stb_o, VEC[i].act);
      chk(tag, "pre", pre_stb_o, VEC[i].pre);
      if (VEC[i].pre) chk(tag, "pre_mask", pre_mask_o, VEC[i].pm);
      chk(tag, "mrs", mrs_stb_o, VEC[i].mrs);
      chk(tag, "illegal", illegal_o, VEC[i].ill);
      chk(tag, "rd", rd_stb_o, VEC[i].rd);
      chk(tag, "wr", wr_stb_o, VEC[i].wr);
      chk(tag, "dq_oe", dq_oe_o, VEC[i].rd);
      if (VEC[i].rd || VEC[i].wr) chk(tag, "col", rw_col_o, VEC[i].col);
      chk(tag, "open", bank_open_o, VEC[i].opn);
    end

    // R3 R4: latched row and bank follow the burst
    step(C_ACT, 2'd1, 13'h1ABC);
    chk("R3", "act_row", act_row_o, 13'h1ABC);
    chk("R3", "act_bank", act_bank_o, 2'd1);
    step(C_RD, 2'd1, 13'h0000);
    chk("R4", "rw_row", rw_row_o, 13'h1ABC);
    chk("R4", "rw_bank", rw_bank_o, 2'd1);
    step(C_BST, 2'd0, 13'h0000);
    step(C_PRE, 2'd0, 13'h0400);
    chk("R3", "open after all", bank_open_o, 0);

    // R11: auto-precharge end meets activate of same bank (BL2)
    step(C_MRS, 2'd0, 13'h0001);
    chk("R8", "mrs bl2", mrs_stb_o, 1);
    step(C_ACT, 2'd3, 13'h0007);
    step(C_RD, 2'd3, 13'h0404);
    chk("R7", "beat0 col", rw_col_o, 10'h004);
    step(C_NOP, 2'd0, 13'h0000);
    chk("R7", "beat1 col", rw_col_o, 10'h005);
    step(C_ACT, 2'd3, 13'h0009);
    chk("R11", "act", act_stb_o, 1);
    chk("R11", "pre", pre_stb_o, 1);
    chk("R11", "pre_mask", pre_mask_o, 4'b1000);
    chk("R11", "illegal", illegal_o, 0);
    chk("R11", "open", bank_open_o, 4'b1000);
    chk("R11", "rd ended", rd_stb_o, 0);

    // R11: read to the bank at the closing edge is illegal
    step(C_RD, 2'd3, 13'h0406);
    step(C_NOP, 2'd0, 13'h0000);
    chk("R4", "wrap col", rw_col_o, 10'h007);
    step(C_RD, 2'd3, 13'h0000);
    chk("R11", "illegal rd", illegal_o, 1);
    chk("R11", "pre", pre_stb_o, 1);
    chk("R11", "rd", rd_stb_o, 0);
    chk("R11", "open", bank_open_o, 4'b0000);

    // R12: reset in the middle of a burst
    step(C_ACT, 2'd0, 13'h0000);
    step(C_RD, 2'd0, 13'h0000);
    chk("R12", "rd before reset", rd_stb_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R12", "rd in reset", rd_stb_o, 0);
    chk("R12", "open in reset", bank_open_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(C_NOP, 2'd0, 13'h0000);
    chk("R12", "idle after reset", {rd_stb_o, wr_stb_o, act_stb_o}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule